// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block lets several requesters build atomic read-modify-write sequences on one shared word memory. Each requester owns a port on which it issues plain stores, load-linked reads and store-conditional writes. A load-linked returns the addressed word one cycle later and arms a reservation for that requester on the address. A later store-conditional from the same requester only reaches memory if that reservation is still armed for the same address. It reports 1 on success and 0 on failure.

A reservation is disarmed by any write to the watched word from a different requester. A successful store-conditional counts as such a write. The issuing requester's own store-conditional also disarms its reservation. The address of every request is formed from a base value plus a signed offset. Requests on all ports are accepted every cycle. When ports conflict on one word in the same cycle, a fixed order by port index settles the outcome, so software spin loops on top of it always make progress.

Top module: `atomic_resv_unit`

## Requirements
- R1: After reset is asserted (active low, asynchronous), every `rsp_valid` bit is 0 and no requester holds a reservation, so a store-conditional issued right after reset fails.
- R2: The effective word address is `req_base` plus `req_imm` sign-extended to the address width, taken modulo 2^ADDR_W.
- R3: The opcode field encodes 2'b00 idle, 2'b01 plain store, 2'b10 load-linked, 2'b11 store-conditional. A load-linked makes `rsp_valid` high in the next cycle, with `rsp_data` holding the memory word as it stood before any write of the request cycle. It also arms the port's reservation on that address.
- R4: A store-conditional whose port holds an armed reservation on the same address writes `req_wdata` to memory and answers 1 in the next cycle.
- R5: A store-conditional without such a reservation (none armed, or armed on another address) answers 0 and leaves memory unchanged.
- R6: A store-conditional disarms its own port's reservation whether it succeeds or fails.
- R7: A plain store from another port to the reserved address disarms the reservation. A plain store from the owning port does not.
- R8: A successful store-conditional disarms reservations on the same address held by all other ports.
- R9: Each port holds a single reservation; a new load-linked replaces the previous one, and the old address is no longer watched.
- R10: When several store-conditionals hit the same word in one cycle, only the lowest-numbered port with a valid reservation succeeds. Every port above it fails.
- R11: If another port writes the word in the same cycle as a load-linked to it, the load-linked returns the old value and no reservation is armed.
- R12: Idle and plain-store requests give no response (`rsp_valid` stays 0 in the next cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | NUM_PORTS x 2 | Per-port request opcode |
| req_base | input | NUM_PORTS x ADDR_W | Per-port base word address |
| req_imm | input | NUM_PORTS x IMM_W | Per-port signed address offset |
| req_wdata | input | NUM_PORTS x DATA_W | Per-port write data for store and store-conditional |
| rsp_valid | output | NUM_PORTS | Per-port response strobe, one cycle after a load-linked or store-conditional |
| rsp_data | output | NUM_PORTS x DATA_W | Loaded word, or 1/0 success flag of a store-conditional |

## Verification
One sequence of two-port request vectors walks through single-port pairs that succeed, pairs broken by a foreign plain store, pairs left intact by the owner's own store, and pairs broken by a foreign successful conditional. Telling these apart shows that disarming depends on who writes and not merely on a write happening. Other vectors replace a reservation with a second load-linked and then target the old address. Others issue two conditionals to one word in the same cycle, and a load-linked that races a foreign store. These separate the port-order rule and the pre-write read value from a design that merely serialises requests. Directed steps then check the state during and after reset and across a mid-run reset.

// File: rtl/atomic_resv_pkg.sv
package atomic_resv_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } resv_op_e;
endpackage

// File: rtl/resv_addr_gen.sv
module resv_addr_gen #(
  parameter int ADDR_W = 8,
  parameter int IMM_W  = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - IMM_W;

  // offset sign-extended to the address width, sum wraps
  assign ea = base + {{EXT_W{imm[IMM_W-1]}}, imm};
endmodule

// File: rtl/resv_slot.sv
module resv_slot #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_en,
  input  logic              arm_ok,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              disarm,
  output logic              armed,
  output logic [ADDR_W-1:0] watch_addr
);
  logic              armed_d;
  logic              addr_en;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    armed_d = armed;
    addr_en = 1'b0;
    addr_d  = watch_addr;
    if (arm_en) begin
      armed_d = arm_ok;
      addr_en = 1'b1;
      addr_d  = arm_addr;
    end else if (disarm) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      watch_addr <= '0;
    end else begin
      armed <= armed_d;
      if (addr_en) watch_addr <= addr_d;
    end
  end
endmodule

// File: rtl/resv_word_store.sv
module resv_word_store #(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr  [NUM_PORTS],
  input  logic              wen   [NUM_PORTS],
  input  logic [DATA_W-1:0] wdata [NUM_PORTS],
  output logic [DATA_W-1:0] rdata [NUM_PORTS]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // later ports are written last, so the highest writer lands
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (wen[p]) mem[addr[p]] <= wdata[p];
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) rdata[p] = mem[addr[p]];
  end
endmodule

// File: rtl/atomic_resv_unit.sv
module atomic_resv_unit
  import atomic_resv_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8,
  parameter int IMM_W     = 6,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0][1:0]         req_op,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  req_base,
  input  logic [NUM_PORTS-1:0][IMM_W-1:0]   req_imm,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  req_wdata,
  output logic [NUM_PORTS-1:0]              rsp_valid,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rsp_data
);
  logic [ADDR_W-1:0] ea       [NUM_PORTS];
  logic [DATA_W-1:0] wd       [NUM_PORTS];
  logic [DATA_W-1:0] rd       [NUM_PORTS];
  logic              is_st    [NUM_PORTS];
  logic              is_ll    [NUM_PORTS];
  logic              is_sc    [NUM_PORTS];
  logic              sc_ok    [NUM_PORTS];
  logic              wr_en    [NUM_PORTS];
  logic              foreign_hit_watch [NUM_PORTS];
  logic              foreign_hit_req   [NUM_PORTS];
  logic              slot_armed [NUM_PORTS];
  logic [ADDR_W-1:0] slot_addr  [NUM_PORTS];

  // packed views for the bound checker
  logic [NUM_PORTS-1:0]             resv_vld;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] resv_addr;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] ea_pk;

  logic [NUM_PORTS-1:0]             rsp_valid_d;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rsp_data_d;

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_port
      resv_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ea (
        .base (req_base[g]),
        .imm  (req_imm[g]),
        .ea   (ea[g])
      );

      resv_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_en     (is_ll[g]),
        .arm_ok     (!foreign_hit_req[g]),
        .arm_addr   (ea[g]),
        .disarm     (is_sc[g] || foreign_hit_watch[g]),
        .armed      (slot_armed[g]),
        .watch_addr (slot_addr[g])
      );
    end
  endgenerate

  resv_word_store #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_mem (
    .clk   (clk),
    .addr  (ea),
    .wen   (wr_en),
    .wdata (wd),
    .rdata (rd)
  );

  // decode and port-ordered conditional arbitration
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      wd[p]    = req_wdata[p];
      is_st[p] = resv_op_e'(req_op[p]) == OP_STORE;
      is_ll[p] = resv_op_e'(req_op[p]) == OP_LINK;
      is_sc[p] = resv_op_e'(req_op[p]) == OP_COND;
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic lower_wrote;
      lower_wrote = 1'b0;
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (q < p && wr_en[q] && ea[q] == ea[p]) lower_wrote = 1'b1;
      end
      sc_ok[p] = is_sc[p] && slot_armed[p] && slot_addr[p] == ea[p] && !lower_wrote;
      wr_en[p] = is_st[p] || sc_ok[p];
    end
  end

  // writes by other ports against each port's watch and new request
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      foreign_hit_watch[p] = 1'b0;
      foreign_hit_req[p]   = 1'b0;
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (q != p && wr_en[q]) begin
          if (ea[q] == slot_addr[p]) foreign_hit_watch[p] = 1'b1;
          if (ea[q] == ea[p])        foreign_hit_req[p]   = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      resv_vld[p]    = slot_armed[p];
      resv_addr[p]   = slot_addr[p];
      ea_pk[p]       = ea[p];
      rsp_valid_d[p] = is_ll[p] || is_sc[p];
      rsp_data_d[p]  = is_ll[p] ? rd[p] : DATA_W'(sc_ok[p]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (rsp_valid_d[p]) rsp_data[p] <= rsp_data_d[p];
      end
    end
  end
endmodule

// File: rtl/atomic_resv_unit_chk.sv
module atomic_resv_unit_chk #(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_PORTS-1:0][1:0]        req_op,
  input logic [NUM_PORTS-1:0]             rsp_valid,
  input logic [NUM_PORTS-1:0][DATA_W-1:0] rsp_data,
  input logic [NUM_PORTS-1:0]             resv_vld,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] resv_addr,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] ea_pk
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_chk
      a_r3_link_answers: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_op[g] == 2'b10) |-> rsp_valid[g]);

      a_r12_quiet_ops: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_op[g] == 2'b00 || req_op[g] == 2'b01) |-> !rsp_valid[g]);

      a_r4_win_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid[g] && $past(req_op[g] == 2'b11) && rsp_data[g] == ONE)
          |-> ($past(resv_vld[g]) && $past(resv_addr[g] == ea_pk[g])));

      a_r6_cond_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_op[g] == 2'b11) |-> !resv_vld[g]);

      if (g > 0) begin : g_pair
        a_r10_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
          ($past(req_op[0] == 2'b11 && req_op[g] == 2'b11 && ea_pk[0] == ea_pk[g])
            && rsp_data[0] == ONE) |-> rsp_data[g] != ONE);
      end
    end
  endgenerate
endmodule

bind atomic_resv_unit atomic_resv_unit_chk #(
  .NUM_PORTS (NUM_PORTS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .resv_vld  (resv_vld),
  .resv_addr (resv_addr),
  .ea_pk     (ea_pk)
);

// File: tb/sim_atomic_resv_unit.sv
module sim_atomic_resv_unit;
  localparam int NP = 2;
  localparam int AW = 8;
  localparam int IW = 6;
  localparam int DW = 32;
  localparam int NV = 22;

  localparam logic [1:0] N = 2'b00, S = 2'b01, L = 2'b10, C = 2'b11;

  typedef struct packed {
    logic [1:0]    o0; logic [AW-1:0] b0; logic [IW-1:0] i0; logic [DW-1:0] d0;
    logic [1:0]    o1; logic [AW-1:0] b1; logic [IW-1:0] i1; logic [DW-1:0] d1;
    logic          v0; logic [DW-1:0] e0;
    logic          v1; logic [DW-1:0] e1;
  } vec_t;

  // port0 request | port1 request | expected port0 | expected port1
  localparam vec_t VEC [NV] = '{
    '{S,8'd10,6'h00,32'hA1, S,8'd20,6'h3E,32'hB2, 1'b0,32'h0, 1'b0,32'h0},   // R2 store at 20-2
    '{L,8'd16,6'h02,32'h0,  L,8'd10,6'h00,32'h0,  1'b1,32'hB2, 1'b1,32'hA1}, // R2 R3
    '{C,8'd18,6'h00,32'hC3, N,8'd0,6'h00,32'h0,   1'b1,32'h1, 1'b0,32'h0},   // R4
    '{C,8'd18,6'h00,32'hD4, L,8'd18,6'h00,32'h0,  1'b1,32'h0, 1'b1,32'hC3},  // R6 fail, R4 mem
    '{S,8'd10,6'h00,32'hE5, N,8'd0,6'h00,32'h0,   1'b0,32'h0, 1'b0,32'h0},   // R12
    '{N,8'd0,6'h00,32'h0,   C,8'd18,6'h00,32'hF6, 1'b0,32'h0, 1'b1,32'h1},   // R9 new watch kept
    '{N,8'd0,6'h00,32'h0,   L,8'd10,6'h00,32'h0,  1'b0,32'h0, 1'b1,32'hE5},  // R3
    '{N,8'd0,6'h00,32'h0,   L,8'd18,6'h00,32'h0,  1'b0,32'h0, 1'b1,32'hF6},  // R9 replace
    '{L,8'd10,6'h00,32'h0,  C,8'd10,6'h00,32'h77, 1'b1,32'hE5, 1'b1,32'h0},  // R9 old addr fails
    '{N,8'd0,6'h00,32'h0,   S,8'd10,6'h00,32'h88, 1'b0,32'h0, 1'b0,32'h0},   // R7 foreign store
    '{C,8'd10,6'h00,32'h99, L,8'd10,6'h00,32'h0,  1'b1,32'h0, 1'b1,32'h88},  // R7 fail, R5 mem
    '{S,8'd30,6'h00,32'h30, S,8'd10,6'h00,32'h11, 1'b0,32'h0, 1'b0,32'h0},   // R7 own store
    '{N,8'd0,6'h00,32'h0,   C,8'd10,6'h00,32'h22, 1'b0,32'h0, 1'b1,32'h1},   // R7 own store keeps
    '{L,8'd30,6'h00,32'h0,  L,8'd30,6'h00,32'h0,  1'b1,32'h30, 1'b1,32'h30}, // R3
    '{C,8'd30,6'h00,32'h31, N,8'd0,6'h00,32'h0,   1'b1,32'h1, 1'b0,32'h0},   // R8 winner
    '{L,8'd30,6'h00,32'h0,  C,8'd30,6'h00,32'h32, 1'b1,32'h31, 1'b1,32'h0},  // R8 loser
    '{N,8'd0,6'h00,32'h0,   L,8'd30,6'h00,32'h0,  1'b0,32'h0, 1'b1,32'h31},  // R3
    '{C,8'd30,6'h00,32'h41, C,8'd30,6'h00,32'h42, 1'b1,32'h1, 1'b1,32'h0},   // R10
    '{L,8'd30,6'h00,32'h0,  N,8'd0,6'h00,32'h0,   1'b1,32'h41, 1'b0,32'h0},  // R10 mem
    '{L,8'd10,6'h00,32'h0,  S,8'd10,6'h00,32'h55, 1'b1,32'h22, 1'b0,32'h0},  // R11 old value
    '{C,8'd10,6'h00,32'h66, L,8'd10,6'h00,32'h0,  1'b1,32'h0, 1'b1,32'h55},  // R11 no watch
    '{L,8'd30,6'h00,32'h0,  C,8'd30,6'h00,32'h77, 1'b1,32'h41, 1'b1,32'h0}   // R5 other addr
  };

  logic                      clk;
  logic                      rst_n;
  logic [NP-1:0][1:0]        req_op;
  logic [NP-1:0][AW-1:0]     req_base;
  logic [NP-1:0][IW-1:0]     req_imm;
  logic [NP-1:0][DW-1:0]     req_wdata;
  logic [NP-1:0]             rsp_valid;
  logic [NP-1:0][DW-1:0]     rsp_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  atomic_resv_unit #(.NUM_PORTS(NP), .ADDR_W(AW), .IMM_W(IW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_base(req_base),
    .req_imm(req_imm), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic [1:0] op, input logic [AW-1:0] b,
                       input logic [IW-1:0] i, input logic [DW-1:0] d);
    req_op[p] = op; req_base[p] = b; req_imm[p] = i; req_wdata[p] = d;
  endtask

  task automatic idle_all();
    for (int p = 0; p < NP; p++) drive(p, N, '0, '0, '0);
  endtask

  // apply at negedge, sample 1 ns after the capturing posedge
  task automatic cycle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    idle_all();
    repeat (2) @(posedge clk);
    #1;
    check(rsp_valid == '0, "R1 valid in reset", DW'(rsp_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: conditional straight after reset has no reservation
    drive(0, C, 8'd40, 6'h00, 32'h5);
    cycle();
    check(rsp_valid[0] && rsp_data[0] == 32'h0, "R1 cond after reset", rsp_data[0], 32'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(0, VEC[k].o0, VEC[k].b0, VEC[k].i0, VEC[k].d0);
      drive(1, VEC[k].o1, VEC[k].b1, VEC[k].i1, VEC[k].d1);
      cycle();
      check(rsp_valid[0] == VEC[k].v0, $sformatf("R3/R12 vec %0d p0 valid", k),
            DW'(rsp_valid[0]), DW'(VEC[k].v0));
      check(rsp_valid[1] == VEC[k].v1, $sformatf("R3/R12 vec %0d p1 valid", k),
            DW'(rsp_valid[1]), DW'(VEC[k].v1));
      if (VEC[k].v0)
        check(rsp_data[0] == VEC[k].e0, $sformatf("vec %0d p0 data", k), rsp_data[0], VEC[k].e0);
      if (VEC[k].v1)
        check(rsp_data[1] == VEC[k].e1, $sformatf("vec %0d p1 data", k), rsp_data[1], VEC[k].e1);
    end

    // R1: reset mid-run drops an armed reservation
    @(negedge clk);
    idle_all();
    drive(0, L, 8'd30, 6'h00, '0);
    cycle();
    check(rsp_data[0] == 32'h41, "R1 arm before reset", rsp_data[0], 32'h41);
    @(negedge clk);
    idle_all();
    rst_n = 1'b0;
    #1;
    check(rsp_valid == '0, "R1 valid cleared async", DW'(rsp_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, C, 8'd30, 6'h00, 32'h99);
    cycle();
    check(rsp_valid[0] && rsp_data[0] == 32'h0, "R1 cond after mid reset", rsp_data[0], 32'h0);
    @(negedge clk);
    idle_all();
    drive(1, L, 8'd30, 6'h00, '0);
    cycle();
    check(rsp_data[1] == 32'h41, "R5 memory kept after failed cond", rsp_data[1], 32'h41);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule